// File: doc/BRIEF.md
# Caller Identification Byte Sender

This block accepts caller identification bytes from a host through a byte write strobe and keeps them in a small byte buffer. It turns them into a serial bit stream for an external modulator. A bit-rate tick sets the pace: each tick moves one bit to the output. While the sender runs, a valid signal accompanies the bit.

With framing switched on, the stream opens with a programmable run of alternating seizure bits and a programmable run of mark bits. Every byte is then wrapped in a start bit and a stop bit. With framing off, the buffered bytes go out as raw bits. A level-triggered request flag asks the host for more data when the buffer runs low. Two sticky flags report underflow and overflow.

The sender can be stopped in two ways. A plain stop cuts the stream at the next bit boundary and discards the buffer. An automatic stop lets the buffer drain completely, then shuts the sender down by itself and keeps every interrupt quiet until the next start.

Top module: `cid_sender`

## Requirements
- R1: The buffer holds at most 48 bytes in write order. A byte written while the buffer is full and nothing is being read in that cycle is discarded, and the bytes already stored are not changed.
- R2: `irq_req` is 1 exactly when the sender is active, `enable` is 1, and the number of buffered bytes is at or below `req_size`. It returns to 0 once the buffer holds more than `req_size` bytes.
- R3: While active, a write to a full buffer sets `irq_overflow`. The flag stays 1 until the next start.
- R4: While active with `enable` at 1, a byte boundary that finds the buffer empty sets `irq_underflow`. For that bit period `tx_bit` is held at 1.
- R5: Each data byte is sent least significant bit first.
- R6: With `frame_en` at 1, a start sends `seize_len` seizure bits (0,1,0,1,... beginning with 0), then `mark_len` mark bits of value 1. Each byte is then sent as a start bit 0, eight data bits and a stop bit 1. A length of zero skips that preamble part.
- R7: With `frame_en` at 0, bytes are sent back to back as eight data bits each, with no preamble, start bit or stop bit.
- R8: `tx_bit` changes only in the clock cycle after a cycle with `bit_tick` at 1. `tx_valid` is 1 exactly while `active` is 1.
- R9: With `auto_stop` at 1, clearing `enable` does not stop the sender at once. The sender sends every buffered byte, including the stop bit of the last byte, and clears `active` on the next tick after that.
- R10: While the sender is inactive, no flag is set, including after an automatic stop. A rising edge of `enable` while inactive starts the sender and clears both sticky flags.
- R11: With `auto_stop` at 0, clearing `enable` stops the sender on the next tick and empties the buffer.
- R12: While inactive, `tx_bit` is 1 and `tx_valid` is 0. The same holds after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| wr_data | input | 8 | Byte to buffer |
| enable | input | 1 | Sender enable; a rising edge starts the sender |
| auto_stop | input | 1 | Drain the buffer, then stop, when enable is cleared |
| frame_en | input | 1 | Add preamble, start bits and stop bits |
| req_size | input | 6 | Low-water request threshold in bytes |
| seize_len | input | 8 | Number of seizure bits |
| mark_len | input | 8 | Number of mark bits |
| bit_tick | input | 1 | One-cycle bit-rate pulse |
| tx_bit | output | 1 | Serial output bit |
| tx_valid | output | 1 | Output bit is part of the stream |
| active | output | 1 | Sender running |
| irq_req | output | 1 | Buffer at or below threshold |
| irq_underflow | output | 1 | Sticky buffer underflow flag |
| irq_overflow | output | 1 | Sticky buffer overflow flag |

## Verification
Two functions can act in the same cycle: a host write reaching a full buffer, and a byte boundary of the serializer taking a byte away. The bench fills the buffer before the start and writes while it is full and nothing is read. It then checks that the overflow flag rises and that the bytes sent afterwards are still the first two written, in order. The drop of a write made while inactive is judged the same way, with the flag required to stay low.

// File: rtl/cid_pkg.sv
package cid_pkg;

    localparam int BYTE_W = 8;

    typedef enum logic [2:0] {
        PH_SEIZE = 3'd0,
        PH_MARK  = 3'd1,
        PH_BYTE  = 3'd2,
        PH_DATA  = 3'd3,
        PH_STOP  = 3'd4
    } phase_e;

    // phase entered when a preamble part of the given length would begin
    function automatic phase_e skip_empty(input logic seize_zero, input logic mark_zero,
                                          input logic at_seize);
        if (at_seize && !seize_zero) return PH_SEIZE;
        if (!mark_zero)              return PH_MARK;
        return PH_BYTE;
    endfunction

endpackage

// File: rtl/cid_byte_fifo.sv
module cid_byte_fifo #(
    parameter int DEPTH = 48,
    localparam int LVL_W = $clog2(DEPTH + 1),
    localparam int PTR_W = $clog2(DEPTH)
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      push,
    input  logic [cid_pkg::BYTE_W-1:0] push_data,
    input  logic                      pop,
    input  logic                      flush,
    output logic [cid_pkg::BYTE_W-1:0] head,
    output logic                      empty,
    output logic                      full,
    output logic                      ovf_evt,
    output logic [LVL_W-1:0]          level
);
    logic [cid_pkg::BYTE_W-1:0] mem [DEPTH];
    logic [PTR_W-1:0] wr_ptr, rd_ptr;
    logic             take, accept;

    assign empty   = (level == '0);
    assign full    = (level == LVL_W'(DEPTH));
    assign take    = pop && !empty;
    assign accept  = push && (!full || take) && !flush;
    assign ovf_evt = push && full && !take && !flush;
    assign head    = mem[rd_ptr];

    function automatic logic [PTR_W-1:0] bump(input logic [PTR_W-1:0] p);
        return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    always_ff @(posedge clk) begin
        if (accept) mem[wr_ptr] <= push_data;
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            level  <= '0;
        end else begin
            if (accept) wr_ptr <= bump(wr_ptr);
            if (take)   rd_ptr <= bump(rd_ptr);
            case ({accept, take})
                2'b10:   level <= level + 1'b1;
                2'b01:   level <= level - 1'b1;
                default: level <= level;
            endcase
        end
    end
endmodule

// File: rtl/cid_serializer.sv
module cid_serializer
    import cid_pkg::*;
#(
    parameter int PRE_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              enable,
    input  logic              auto_stop,
    input  logic              frame_en,
    input  logic [PRE_W-1:0]  seize_len,
    input  logic [PRE_W-1:0]  mark_len,
    input  logic              bit_tick,
    input  logic              buf_empty,
    input  logic [BYTE_W-1:0] buf_head,
    output logic              pop,
    output logic              flush,
    output logic              start,
    output logic              unf_evt,
    output logic              active,
    output logic              tx_bit
);
    localparam int BIT_CW = $clog2(BYTE_W);

    phase_e            phase;
    logic [PRE_W-1:0]  pre_cnt;
    logic [BIT_CW-1:0] bit_cnt;
    logic [BYTE_W-1:0] shreg;
    logic              en_q;
    logic              step, abort, at_byte;

    assign start   = enable && !en_q && !active;
    assign step    = active && bit_tick;
    assign abort   = step && !enable && !auto_stop;
    assign at_byte = step && !abort && (phase == PH_BYTE);
    assign pop     = at_byte && !buf_empty;
    assign unf_evt = at_byte && buf_empty && enable;
    assign flush   = abort;

    always_ff @(posedge clk) begin
        if (rst) begin
            en_q    <= 1'b0;
            active  <= 1'b0;
            tx_bit  <= 1'b1;
            phase   <= PH_BYTE;
            pre_cnt <= '0;
            bit_cnt <= '0;
            shreg   <= '0;
        end else begin
            en_q <= enable;
            if (start) begin
                active  <= 1'b1;
                tx_bit  <= 1'b1;
                pre_cnt <= '0;
                bit_cnt <= '0;
                phase   <= frame_en ? skip_empty(seize_len == '0, mark_len == '0, 1'b1)
                                    : PH_BYTE;
            end else if (abort) begin
                active <= 1'b0;
                tx_bit <= 1'b1;
                phase  <= PH_BYTE;
            end else if (step) begin
                unique case (phase)
                    PH_SEIZE: begin
                        tx_bit <= pre_cnt[0];
                        if (pre_cnt == seize_len - 1'b1) begin
                            pre_cnt <= '0;
                            phase   <= skip_empty(1'b1, mark_len == '0, 1'b0);
                        end else begin
                            pre_cnt <= pre_cnt + 1'b1;
                        end
                    end
                    PH_MARK: begin
                        tx_bit <= 1'b1;
                        if (pre_cnt == mark_len - 1'b1) begin
                            pre_cnt <= '0;
                            phase   <= PH_BYTE;
                        end else begin
                            pre_cnt <= pre_cnt + 1'b1;
                        end
                    end
                    PH_BYTE: begin
                        if (!buf_empty) begin
                            phase <= PH_DATA;
                            if (frame_en) begin
                                tx_bit  <= 1'b0;
                                shreg   <= buf_head;
                                bit_cnt <= '0;
                            end else begin
                                tx_bit  <= buf_head[0];
                                shreg   <= buf_head >> 1;
                                bit_cnt <= BIT_CW'(1);
                            end
                        end else begin
                            tx_bit <= 1'b1;
                            if (!enable) active <= 1'b0;
                        end
                    end
                    PH_DATA: begin
                        tx_bit <= shreg[0];
                        shreg  <= shreg >> 1;
                        if (bit_cnt == BIT_CW'(BYTE_W - 1)) begin
                            bit_cnt <= '0;
                            phase   <= frame_en ? PH_STOP : PH_BYTE;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    PH_STOP: begin
                        tx_bit <= 1'b1;
                        phase  <= PH_BYTE;
                    end
                    default: phase <= PH_BYTE;
                endcase
            end
        end
    end
endmodule

// File: rtl/cid_irq_flags.sv
module cid_irq_flags #(
    parameter int LVL_W = 6
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             active,
    input  logic             enable,
    input  logic [LVL_W-1:0] level,
    input  logic [LVL_W-1:0] req_size,
    input  logic             ovf_evt,
    input  logic             unf_evt,
    output logic             irq_req,
    output logic             irq_underflow,
    output logic             irq_overflow
);
    assign irq_req = active && enable && (level <= req_size);

    always_ff @(posedge clk) begin
        if (rst || start) begin
            irq_underflow <= 1'b0;
            irq_overflow  <= 1'b0;
        end else if (active) begin
            if (unf_evt) irq_underflow <= 1'b1;
            if (ovf_evt) irq_overflow  <= 1'b1;
        end
    end
endmodule

// File: rtl/cid_sender.sv
module cid_sender #(
    parameter int DEPTH = 48,
    parameter int PRE_W = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_en,
    input  logic [7:0]       wr_data,
    input  logic             enable,
    input  logic             auto_stop,
    input  logic             frame_en,
    input  logic [LVL_W-1:0] req_size,
    input  logic [PRE_W-1:0] seize_len,
    input  logic [PRE_W-1:0] mark_len,
    input  logic             bit_tick,
    output logic             tx_bit,
    output logic             tx_valid,
    output logic             active,
    output logic             irq_req,
    output logic             irq_underflow,
    output logic             irq_overflow
);
    logic [7:0]       head;
    logic             empty, full, ovf_evt, unf_evt;
    logic             pop, flush, start;
    logic [LVL_W-1:0] fill_level;

    cid_byte_fifo #(.DEPTH(DEPTH)) fifo_i (
        .clk(clk), .rst(rst), .push(wr_en), .push_data(wr_data),
        .pop(pop), .flush(flush), .head(head), .empty(empty),
        .full(full), .ovf_evt(ovf_evt), .level(fill_level)
    );

    cid_serializer #(.PRE_W(PRE_W)) ser_i (
        .clk(clk), .rst(rst), .enable(enable), .auto_stop(auto_stop),
        .frame_en(frame_en), .seize_len(seize_len), .mark_len(mark_len),
        .bit_tick(bit_tick), .buf_empty(empty), .buf_head(head),
        .pop(pop), .flush(flush), .start(start), .unf_evt(unf_evt),
        .active(active), .tx_bit(tx_bit)
    );

    cid_irq_flags #(.LVL_W(LVL_W)) flags_i (
        .clk(clk), .rst(rst), .start(start), .active(active),
        .enable(enable), .level(fill_level), .req_size(req_size),
        .ovf_evt(ovf_evt), .unf_evt(unf_evt), .irq_req(irq_req),
        .irq_underflow(irq_underflow), .irq_overflow(irq_overflow)
    );

    assign tx_valid = active;
endmodule

// File: rtl/cid_sender_chk.sv
module cid_sender_chk #(
    parameter int DEPTH = 48,
    parameter int LVL_W = 6
) (
    input logic             clk,
    input logic             rst,
    input logic             bit_tick,
    input logic             tx_bit,
    input logic             active,
    input logic             irq_overflow,
    input logic             irq_underflow,
    input logic [LVL_W-1:0] fill_level
);
    // R1
    a_r1_fill_bound: assert property (@(posedge clk) disable iff (rst)
        fill_level <= LVL_W'(DEPTH));
    // R8
    a_r8_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
        !bit_tick |=> $stable(tx_bit));
    // R12
    a_r12_idle_mark: assert property (@(posedge clk) disable iff (rst)
        !active |-> tx_bit);
    // R3
    a_r3_overflow_sticky: assert property (@(posedge clk) disable iff (rst)
        (irq_overflow && active) |=> irq_overflow);
    // R10
    a_r10_quiet_when_idle: assert property (@(posedge clk) disable iff (rst)
        !active |=> !$rose(irq_overflow) && !$rose(irq_underflow));
    // R9 / R11: stopping happens only on a bit boundary
    a_r9_stop_on_tick: assert property (@(posedge clk) disable iff (rst)
        $fell(active) |-> $past(bit_tick));
endmodule

bind cid_sender cid_sender_chk #(.DEPTH(DEPTH), .LVL_W(LVL_W)) chk_i (
    .clk(clk), .rst(rst), .bit_tick(bit_tick), .tx_bit(tx_bit),
    .active(active), .irq_overflow(irq_overflow),
    .irq_underflow(irq_underflow), .fill_level(fill_level)
);

// File: tb/cid_sender_tb_top.sv
module cid_sender_tb_top;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_en = 1'b0;
    logic [7:0] wr_data = '0;
    logic       enable = 1'b0, auto_stop = 1'b0, frame_en = 1'b0;
    logic [5:0] req_size = '0;
    logic [7:0] seize_len = '0, mark_len = '0;
    logic       bit_tick = 1'b0;
    logic       tx_bit, tx_valid, active, irq_req, irq_underflow, irq_overflow;

    int checks = 0;
    int errors = 0;

    always #10 clk = ~clk;

    cid_sender dut_i (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data),
        .enable(enable), .auto_stop(auto_stop), .frame_en(frame_en),
        .req_size(req_size), .seize_len(seize_len), .mark_len(mark_len),
        .bit_tick(bit_tick), .tx_bit(tx_bit), .tx_valid(tx_valid),
        .active(active), .irq_req(irq_req), .irq_underflow(irq_underflow),
        .irq_overflow(irq_overflow)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); wr_en = 1'b1; wr_data = b;
        @(negedge clk); wr_en = 1'b0;
    endtask

    // one bit period: tick for one cycle, sample the new bit after the edge
    task automatic tick(output logic b);
        @(negedge clk); bit_tick = 1'b1;
        @(negedge clk); bit_tick = 1'b0; b = tx_bit;
        @(negedge clk);
    endtask

    task automatic expect_bit(input string req, input logic exp);
        logic b;
        tick(b);
        chk(req, b, exp);
        chk({req, " valid"}, tx_valid, 1);
    endtask

    task automatic expect_byte(input string req, input logic [7:0] v);
        for (int i = 0; i < 8; i++) expect_bit(req, v[i]);
    endtask

    task automatic test_reset();
        chk("R12 reset tx_bit", tx_bit, 1);
        chk("R12 reset tx_valid", tx_valid, 0);
        chk("R12 reset active", active, 0);
        chk("R10 reset flags", {irq_req, irq_underflow, irq_overflow}, 0);
    endtask

    task automatic test_framed_auto();
        logic [7:0] d [4] = '{8'hA5, 8'h3C, 8'h0F, 8'h81};
        logic b;
        frame_en = 1; seize_len = 4; mark_len = 3; req_size = 2; auto_stop = 1;
        for (int i = 0; i < 4; i++) put(d[i]);
        @(negedge clk); enable = 1;
        @(negedge clk);
        chk("R8 active after start", active, 1);
        chk("R8 valid after start", tx_valid, 1);
        for (int i = 0; i < 4; i++) expect_bit("R6 seizure", logic'(i % 2));
        for (int i = 0; i < 3; i++) expect_bit("R6 mark", 1'b1);
        for (int k = 0; k < 4; k++) begin
            expect_bit("R6 start bit", 1'b0);
            if (k == 0) chk("R2 req low above threshold", irq_req, 0);
            if (k == 1) chk("R2 req high at threshold", irq_req, 1);
            if (k == 2) begin
                @(negedge clk); enable = 0;
                @(negedge clk);
                chk("R2 req gated by enable", irq_req, 0);
            end
            expect_byte("R5 lsb first framed", d[k]);
            expect_bit("R6 stop bit", 1'b1);
            chk("R9 still draining", active, 1);
        end
        tick(b);
        chk("R9 auto stop active", active, 0);
        chk("R9 auto stop valid", tx_valid, 0);
        chk("R10 no underflow after drain", irq_underflow, 0);
    endtask

    task automatic test_raw_overflow();
        logic b;
        for (int i = 0; i < 48; i++) put(8'h10 + 8'(i));
        put(8'hEE);
        chk("R10 no overflow while idle", irq_overflow, 0);
        frame_en = 0; auto_stop = 0; req_size = 2;
        @(negedge clk); enable = 1;
        @(negedge clk);
        chk("R2 req low when full", irq_req, 0);
        put(8'hDD);
        chk("R3 overflow set", irq_overflow, 1);
        expect_byte("R7 raw byte 0 R1 order", 8'h10);
        expect_byte("R7 raw byte 1 R1 order", 8'h11);
        chk("R3 overflow still set", irq_overflow, 1);
        @(negedge clk); enable = 0;
        tick(b);
        chk("R11 stop on next tick", active, 0);
        chk("R12 idle tx_bit", b, 1);
        @(negedge clk); enable = 1;
        @(negedge clk);
        chk("R10 start clears overflow", irq_overflow, 0);
        chk("R11 buffer flushed req", irq_req, 1);
        tick(b);
        chk("R4 underflow set", irq_underflow, 1);
        chk("R4 line held at one", b, 1);
        chk("R11 still active", active, 1);
        @(negedge clk); enable = 0;
        tick(b);
        chk("R11 stopped", active, 0);
    endtask

    task automatic test_no_preamble();
        logic b;
        frame_en = 1; seize_len = 0; mark_len = 0; auto_stop = 1;
        put(8'h5A);
        @(negedge clk); enable = 1;
        @(negedge clk); enable = 0;
        expect_bit("R6 zero preamble start", 1'b0);
        expect_byte("R5 single byte", 8'h5A);
        expect_bit("R6 stop bit", 1'b1);
        tick(b);
        chk("R9 auto stop single byte", active, 0);
        chk("R10 flags quiet", {irq_underflow, irq_overflow}, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        test_reset();
        test_framed_auto();
        test_raw_overflow();
        test_no_preamble();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule